// File: doc/BRIEF.md
# Latch Event FIFO Register Interface

This block is the register front end of a 64-channel hit latch. A simple synchronous register bus (address, write enable, read enable, write data, read data) sets up a delay/window configuration word and a status mode, and turns trigger acceptance on and off. Trigger acceptance is switched by command offsets: the write is what counts, and the data written is ignored.

While triggering is on, every 64-bit latched event is stored whole in a 16-deep event FIFO. Software reads the event count, then drains each event through one data offset as two 32-bit words. The low word carries channels 0 to 31 and the high word carries channels 32 to 63. An event that arrives while the FIFO is full is discarded, and a sticky overflow flag records the loss.

Top module: `evt_fifo_regif`

## Requirements
- R1: After reset, trig_en_o is 0, cfg_o and mode_o are 0, the event count is 0, the overflow flag is 0 and rdata_o is 0.
- R2: A write to offset 0x00C loads all 32 bits of the delay/window configuration. The value appears on cfg_o and reads back from 0x00C.
- R3: A write to offset 0x028 sets trig_en_o and a write to 0x02C clears it, whatever the write data is. The change is visible on the cycle after the write.
- R4: A write to offset 0x000 loads the status mode from write data bits [3:0]. The mode appears on mode_o and reads back from 0x000 with the upper bits as zero.
- R5: event_valid_i stores an event only while trig_en_o is 1. At other times it has no effect on the count or on the FIFO contents.
- R6: A read of offset 0x008 returns the number of stored events in bits [4:0] and the overflow flag in bit 31. All other bits read as zero.
- R7: Reads of offset 0x100 return the oldest event as two words. The first word has bit n = channel n (0..31) and the second has bit n = channel 32+n. The count drops by one only after the second word has been read.
- R8: Events are read out in the order in which they were accepted.
- R9: A read of 0x100 while the FIFO is empty returns 0 and leaves the count and the word order unchanged.
- R10: The FIFO holds 16 events. An event offered while 16 are held is dropped and sets the overflow flag, which then stays set until reset.
- R11: rdata_o updates on the cycle after a read request and holds its value when no read is made. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Register byte offset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| event_valid_i | input | 1 | Latched event present this cycle |
| event_bits_i | input | 64 | Channel hit bits, bit n = channel n |
| trig_en_o | output | 1 | High while triggering is enabled |
| cfg_o | output | 32 | Delay/window configuration |
| mode_o | output | 4 | FIFO status mode |

## Verification
The embedded assertions check on every cycle the timing of the trigger commands, that the count never exceeds the depth, that the overflow flag is sticky, that events are ignored while triggering is off, that an empty read changes nothing, and that read data holds between reads. Only the bench scenarios can show the actual data path. These cover the channel-to-bit mapping in both words, FIFO ordering across a wrap, the identity of the event dropped on overflow, the count value read through the bus, and readback of the configuration and mode registers.

// File: rtl/evt_regif_pkg.sv
package evt_regif_pkg;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFF_MODE     = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_COUNT    = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_CFG      = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_TRIG_ON  = 12'h028;
  localparam logic [ADDR_W-1:0] OFF_TRIG_OFF = 12'h02C;
  localparam logic [ADDR_W-1:0] OFF_DATA     = 12'h100;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MODE, SEL_COUNT, SEL_CFG, SEL_DATA
  } rd_sel_e;

  function automatic rd_sel_e decode_rd(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_MODE:  return SEL_MODE;
      OFF_COUNT: return SEL_COUNT;
      OFF_CFG:   return SEL_CFG;
      OFF_DATA:  return SEL_DATA;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/evt_ctrl_regs.sv
module evt_ctrl_regs
  import evt_regif_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cfg_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              trig_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o     <= '0;
      mode_o    <= '0;
      trig_en_o <= 1'b0;
    end else if (wr_en_i) begin
      case (addr_i)
        OFF_CFG:      cfg_o     <= wdata_i;
        OFF_MODE:     mode_o    <= wdata_i[MODE_W-1:0];
        OFF_TRIG_ON:  trig_en_o <= 1'b1;
        OFF_TRIG_OFF: trig_en_o <= 1'b0;
        default: ;
      endcase
    end
  end

  // R3
  trig_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_TRIG_ON) |=> trig_en_o);
  // R3
  trig_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_TRIG_OFF) |=> !trig_en_o);
  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == OFF_CFG) |=> $stable(cfg_o));
endmodule

// File: rtl/evt_store.sv
module evt_store #(
  parameter int EV_W   = 64,
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int WORDS = EV_W / WORD_W,
  localparam int SEL_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [EV_W-1:0]   push_data_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              ovf_o
);
  logic [EV_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [SEL_W-1:0] word_sel;
  logic [EV_W-1:0]  head;
  logic empty, full, do_push, pop_word, pop_evt, last_word;

  assign empty     = (count_o == '0);
  assign full      = (count_o == CNT_W'(DEPTH));
  assign do_push   = push_i && !full;
  assign last_word = (word_sel == SEL_W'(WORDS - 1));
  assign pop_word  = pop_i && !empty;
  assign pop_evt   = pop_word && last_word;

  always_comb begin
    head   = mem[rd_ptr];
    word_o = empty ? '0 : head[int'(word_sel)*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      word_sel <= '0;
      count_o  <= '0;
      ovf_o    <= 1'b0;
    end else begin
      if (do_push)
        wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      if (pop_evt) begin
        rd_ptr   <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
        word_sel <= '0;
      end else if (pop_word) begin
        word_sel <= word_sel + SEL_W'(1);
      end
      count_o <= count_o + CNT_W'(do_push) - CNT_W'(pop_evt);
      if (push_i && full) ovf_o <= 1'b1;
    end
  end

  // R10
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));
  // R10
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  // R10
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && count_o == CNT_W'(DEPTH) && !pop_i) |=> (ovf_o && count_o == CNT_W'(DEPTH)));
  // R9
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && count_o == '0 && !push_i) |=> (count_o == '0 && $stable(word_sel)));
  // R7
  first_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && count_o != '0 && word_sel == '0) |=> $stable(count_o));
endmodule

// File: rtl/evt_fifo_regif.sv
module evt_fifo_regif
  import evt_regif_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHAN_N = 64,
  parameter int DEPTH  = 16,
  parameter int MODE_W = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              event_valid_i,
  input  logic [CHAN_N-1:0] event_bits_i,
  output logic              trig_en_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic [MODE_W-1:0] mode_o
);
  logic [DATA_W-1:0] fifo_word, count_word, rd_next;
  logic [CNT_W-1:0]  ev_count;
  logic              ovf, push, pop;
  rd_sel_e           sel;

  evt_ctrl_regs #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .cfg_o, .mode_o, .trig_en_o
  );

  assign sel  = decode_rd(addr_i);
  assign push = event_valid_i && trig_en_o;
  assign pop  = rd_en_i && (sel == SEL_DATA);

  evt_store #(.EV_W(CHAN_N), .WORD_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .push_i(push), .push_data_i(event_bits_i), .pop_i(pop),
    .word_o(fifo_word), .count_o(ev_count), .ovf_o(ovf)
  );

  always_comb begin
    count_word = '0;
    count_word[CNT_W-1:0] = ev_count;
    count_word[DATA_W-1]  = ovf;
    case (sel)
      SEL_MODE:  rd_next = DATA_W'(mode_o);
      SEL_COUNT: rd_next = count_word;
      SEL_CFG:   rd_next = cfg_o;
      SEL_DATA:  rd_next = fifo_word;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_next;
  end

  // R5
  gate_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_en_o && !pop) |=> $stable(ev_count));
  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/sim_evt_fifo_regif.sv
module sim_evt_fifo_regif;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, ev_valid = 1'b0;
  logic [31:0] wdata = '0, rdata, cfg;
  logic [63:0] ev_bits = '0;
  logic        trig_en;
  logic [3:0]  mode;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evt_fifo_regif u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .event_valid_i(ev_valid), .event_bits_i(ev_bits),
    .trig_en_o(trig_en), .cfg_o(cfg), .mode_o(mode)
  );

  // {is_write, addr, data, expected read}
  localparam int NV = 9;
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 12'h00C, 32'h0000_0B0E, 32'h0},
    {1'b0, 12'h00C, 32'h0,         32'h0000_0B0E},  // R2
    {1'b1, 12'h000, 32'hFFFF_FFF5, 32'h0},
    {1'b0, 12'h000, 32'h0,         32'h0000_0005},  // R4
    {1'b0, 12'h008, 32'h0,         32'h0},          // R6
    {1'b0, 12'h200, 32'h0,         32'h0},          // R11 unmapped
    {1'b0, 12'h100, 32'h0,         32'h0},          // R9 empty
    {1'b1, 12'h00C, 32'hDEAD_0001, 32'h0},
    {1'b0, 12'h00C, 32'h0,         32'hDEAD_0001}   // R2
  };

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic push_ev(input logic [63:0] e);
    @(negedge clk); ev_bits = e; ev_valid = 1'b1;
    @(negedge clk); ev_valid = 1'b0;
  endtask

  function automatic logic [63:0] ev(input int i);
    return {32'hA500_0000 + 32'(i), 32'h0000_1000 + 32'(i * 3)};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1
    check("R1 trig", trig_en, 0);
    check("R1 cfg", cfg, 0);
    check("R1 mode", mode, 0);
    check("R1 rdata", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(12'h008, d); check("R1 count", d, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr(VEC[i][75:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][75:64], d);
        check($sformatf("R2/R4/R6/R9/R11 vec%0d", i), d, VEC[i][31:0]);
      end
    end
    check("R2 cfg port", cfg, 32'hDEAD_0001);
    check("R4 mode port", mode, 4'h5);

    // R5: events ignored while disabled
    push_ev(ev(99));
    rd(12'h008, d); check("R5 count disabled", d, 0);

    // R3: enable regardless of data
    wr(12'h028, 32'h0);
    check("R3 enable", trig_en, 1);

    // R7/R8: two events, ordering and word split
    push_ev(64'hFE00_0000_0000_0032 | 64'h0000_0000_1800_0000);
    push_ev(ev(1));
    rd(12'h008, d); check("R6 count two", d, 2);
    rd(12'h100, d); check("R7 low word ch0-31", d, 32'h1800_0032);
    rd(12'h008, d); check("R7 count after first word", d, 2);
    rd(12'h100, d); check("R7 high word ch32-63", d, 32'hFE00_0000);
    rd(12'h008, d); check("R7 count after second word", d, 1);
    rd(12'h100, d); check("R8 second event low", d, ev(1)[31:0]);
    rd(12'h100, d); check("R8 second event high", d, ev(1)[63:32]);
    rd(12'h100, d); check("R9 empty read", d, 0);
    rd(12'h008, d); check("R9 count stays", d, 0);

    // R11: hold between reads
    push_ev(ev(7));
    rd(12'h100, d);
    repeat (3) @(negedge clk);
    check("R11 hold", rdata, ev(7)[31:0]);
    rd(12'h100, d); check("R9 word order kept", d, ev(7)[63:32]);

    // R10: fill 16, drop 17th
    for (int i = 0; i < 17; i++) push_ev(ev(10 + i));
    rd(12'h008, d); check("R10 full with overflow", d, 32'h8000_0010);
    for (int i = 0; i < 16; i++) begin
      logic [31:0] lo, hi;
      rd(12'h100, lo); rd(12'h100, hi);
      check($sformatf("R8/R10 drain %0d", i), {hi, lo}, ev(10 + i));
    end
    rd(12'h008, d); check("R10 sticky after drain", d, 32'h8000_0000);

    // R3/R5: disable with all-ones data, then events ignored
    wr(12'h02C, 32'hFFFF_FFFF);
    check("R3 disable", trig_en, 0);
    push_ev(ev(200));
    rd(12'h008, d); check("R5 count after disable", d, 32'h8000_0000);
    rd(12'h100, d); check("R5 nothing stored", d, 0);

    finish_run();
  end
endmodule